// File: doc/BRIEF.md
# Symbol-Wide Pseudo-Random Channel Error Injector

This block stands between a 3-bit-symbol block encoder and its decoder and damages the symbol stream in a repeatable way, so that the decoder's correction path can be exercised. Its noise source is a seven-stage shift register in which every stage holds a whole symbol instead of a single bit. Each clock the stages move one place towards the last stage, and the sum (bitwise XOR) of the last and the first stage is written back into the first. The symbol in the last stage is the noise symbol for that cycle.

Incoming symbols are grouped into codewords of seven valid symbols. Within a codeword, the first valid symbol that meets a noise symbol whose trigger bit is set gets that noise symbol XORed into it and is flagged. The rest of the codeword passes through untouched, so a decoder that corrects one symbol per codeword should always recover the data. Software or a test sequencer restarts the sequence at any time by loading seven independent seed symbols. An all-zero seed, which would freeze the register, is replaced by a fixed nonzero pattern.

Top module: `rsch_chan_err`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to `out_valid`=0, `sym_out`=0, `err_flag`=0, and the register takes the fallback pattern. With the default parameters, stage k takes bits [3k+2:3k] of octal 1234567, so stage 0 holds 7 and stage 6 holds 1.
- R2: A clock edge with `seed_load` high loads stage k from `seed_bus[3k+2:3k]`, with no shift in that cycle, and restarts codeword framing at symbol position 0 with no error yet injected.
- R3: If `seed_bus` is all zero during a load, the register takes the fallback pattern of R1 instead. The register state is never all zero out of reset.
- R4: On every clock without reset or load, stage k takes the old stage k-1 for k=1..6, and stage 0 takes old stage 6 XOR old stage 0. The noise symbol of a cycle is the value of stage 6 before that edge.
- R5: An accepted valid symbol is corrupted when bit 2 of the noise symbol is 1, the noise symbol is nonzero, no symbol of the current codeword has been corrupted yet, and `seed_load` is low. The output is then `sym_in` XOR noise with `err_flag`=1.
- R6: A codeword is seven consecutive valid symbols counted from reset or the last load, and at most one of them carries `err_flag`=1.
- R7: A valid symbol that is not corrupted appears on `sym_out` unchanged, with `err_flag`=0.
- R8: Outputs are registered one clock after the input. `out_valid` equals the `sym_valid` of the previous edge, and while `out_valid` is 0 both `sym_out` and `err_flag` are 0.
- R9: A valid symbol presented in the same cycle as `seed_load` passes through uncorrupted and does not count towards any codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Load the seed symbols and restart framing |
| seed_bus | input | 21 | Seven seed symbols, stage k in bits [3k+2:3k] |
| sym_valid | input | 1 | Codeword symbol present on `sym_in` |
| sym_in | input | 3 | Codeword symbol from the encoder |
| out_valid | output | 1 | Registered copy of `sym_valid` |
| sym_out | output | 3 | Symbol towards the decoder, possibly corrupted |
| err_flag | output | 1 | This output symbol was corrupted |

## Verification
On every cycle, the assertions check the following: the seed or fallback capture, the one-place shift of the stages, a state that never reaches zero, the one-hit limit against the framing state, the pass-through and corrupt output forms, and the quiet outputs of idle cycles. Only the bench's reference model can show that the XOR feedback produces the right sequence over many cycles, and that injection lands on exactly the right symbol of each codeword. The same holds for the framing across gaps in `sym_valid`, a mid-codeword reload and a reload carrying a symbol, since those depend on the whole history.

// File: rtl/rsch_pkg.sv
// Package rsch_pkg
// Shared defaults and the per-cycle action type for the channel error injector.
// Assumes: symbols are narrow (a few bits) and codewords are short.
package rsch_pkg;
    localparam int unsigned SYM_W_DEF  = 3;
    localparam int unsigned STAGES_DEF = 7;
    localparam int unsigned CW_LEN_DEF = 7;

    // What the output stage does with the symbol of the current cycle.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_PASS   = 2'd1,
        ACT_HIT    = 2'd2,
        ACT_RESEED = 2'd3
    } act_e;
endpackage

// File: rtl/rsch_sym_lfsr.sv
// Module rsch_sym_lfsr
// Shift register of STAGES symbol-wide stages. XOR feedback from the last and
// the first stage re-enters the first stage every clock. Seeds load in parallel.
// An all-zero seed is swapped for FALLBACK so the register never locks at zero.
// Assumes: FALLBACK is nonzero; STAGES >= 2.
module rsch_sym_lfsr #(
    parameter int unsigned SYM_W    = rsch_pkg::SYM_W_DEF,
    parameter int unsigned STAGES   = rsch_pkg::STAGES_DEF,
    parameter logic [STAGES*SYM_W-1:0] FALLBACK = 21'o1234567
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      seed_load,
    input  logic [STAGES*SYM_W-1:0]   seed_bus,
    output logic [SYM_W-1:0]          noise_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][SYM_W-1:0] stg_q;
    logic [STAGES-1:0][SYM_W-1:0] stg_d;
    logic [SYM_W-1:0]             fb;
    logic                         seed_zero;

    assign seed_zero = (seed_bus == '0);
    assign fb        = stg_q[LAST] ^ stg_q[0];
    assign noise_o   = stg_q[LAST];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        // Next value of one stage: reset pattern, seed, or shift/feedback.
        always_comb begin
            if (!rst_n) begin
                stg_d[k] = FALLBACK[k*SYM_W +: SYM_W];
            end else if (seed_load) begin
                stg_d[k] = seed_zero ? FALLBACK[k*SYM_W +: SYM_W]
                                     : seed_bus[k*SYM_W +: SYM_W];
            end else begin
                if (k == 0) begin
                    stg_d[k] = fb;
                end else begin
                    stg_d[k] = stg_q[(k == 0) ? 0 : k-1];
                end
            end
        end

        // Stage storage.
        always_ff @(posedge clk) begin
            stg_q[k] <= stg_d[k];
        end
    end

    p_seed_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load && (seed_bus != '0) |=> stg_q == $past(seed_bus));

    p_zero_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load && (seed_bus == '0) |=> stg_q == FALLBACK);

    p_never_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q != '0);

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |=> stg_q[1] == $past(stg_q[0]));
endmodule

// File: rtl/rsch_frame_ctr.sv
// Module rsch_frame_ctr
// Counts accepted valid symbols into codewords of CW_LEN and remembers whether
// the current codeword has already been corrupted.
// Assumes: restart (seed load) outranks a symbol in the same cycle.
module rsch_frame_ctr #(
    parameter int unsigned CW_LEN = rsch_pkg::CW_LEN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sym_valid,
    input  logic inject_i,
    output logic hit_o
);
    localparam int unsigned POS_W = (CW_LEN > 1) ? $clog2(CW_LEN) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(CW_LEN - 1);

    logic [POS_W-1:0] pos_q;
    logic             hit_q;

    assign hit_o = hit_q;

    // Position and hit tracking, cleared at each codeword boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q <= '0;
            hit_q <= 1'b0;
        end else if (sym_valid) begin
            if (pos_q == POS_LAST) begin
                pos_q <= '0;
                hit_q <= 1'b0;
            end else begin
                pos_q <= pos_q + 1'b1;
                hit_q <= hit_q | inject_i;
            end
        end
    end

    p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> !inject_i);

    p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_LAST);
endmodule

// File: rtl/rsch_inject.sv
// Module rsch_inject
// Decides per cycle whether the incoming symbol is corrupted and registers the
// output symbol, valid and flag.
// Assumes: hit_done comes from a register, so inject_o has no loop through it.
module rsch_inject #(
    parameter int unsigned SYM_W    = rsch_pkg::SYM_W_DEF,
    parameter int unsigned TRIG_BIT = SYM_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_in,
    input  logic [SYM_W-1:0] noise,
    input  logic             hit_done,
    output logic             inject_o,
    output logic             out_valid,
    output logic [SYM_W-1:0] sym_out,
    output logic             err_flag
);
    import rsch_pkg::*;

    act_e             act;
    logic             valid_q;
    logic             err_q;
    logic [SYM_W-1:0] sym_q;

    // Classify the current cycle.
    always_comb begin
        if (!sym_valid) begin
            act = ACT_IDLE;
        end else if (seed_load) begin
            act = ACT_RESEED;
        end else if (!hit_done && noise[TRIG_BIT] && (noise != '0)) begin
            act = ACT_HIT;
        end else begin
            act = ACT_PASS;
        end
    end

    assign inject_o  = (act == ACT_HIT);
    assign out_valid = valid_q;
    assign sym_out   = sym_q;
    assign err_flag  = err_q;

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            sym_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (act)
                ACT_HIT: begin
                    valid_q <= 1'b1;
                    sym_q   <= sym_in ^ noise;
                    err_q   <= 1'b1;
                end
                ACT_PASS, ACT_RESEED: begin
                    valid_q <= 1'b1;
                    sym_q   <= sym_in;
                    err_q   <= 1'b0;
                end
                default: begin
                    valid_q <= 1'b0;
                    sym_q   <= '0;
                    err_q   <= 1'b0;
                end
            endcase
        end
    end

    p_hit_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inject_o |=> err_q && valid_q && (sym_q != $past(sym_in)));

    p_pass_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !inject_o |=> valid_q && !err_q && (sym_q == $past(sym_in)));

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> !valid_q);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> (sym_q == '0) && !err_q);

    p_reseed_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !err_q);
endmodule

// File: rtl/rsch_chan_err.sv
// Module rsch_chan_err
// Channel error injector: symbol-wide pseudo-random register, codeword framing
// and a registered injection stage, wired together.
// Assumes: seed_bus is only sampled in cycles with seed_load high.
module rsch_chan_err #(
    parameter int unsigned SYM_W    = rsch_pkg::SYM_W_DEF,
    parameter int unsigned STAGES   = rsch_pkg::STAGES_DEF,
    parameter int unsigned CW_LEN   = rsch_pkg::CW_LEN_DEF,
    parameter int unsigned TRIG_BIT = SYM_W - 1,
    parameter logic [STAGES*SYM_W-1:0] FALLBACK = 21'o1234567
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seed_load,
    input  logic [STAGES*SYM_W-1:0] seed_bus,
    input  logic                    sym_valid,
    input  logic [SYM_W-1:0]        sym_in,
    output logic                    out_valid,
    output logic [SYM_W-1:0]        sym_out,
    output logic                    err_flag
);
    logic [SYM_W-1:0] noise;
    logic             hit_done;
    logic             inject;

    rsch_sym_lfsr #(
        .SYM_W    (SYM_W),
        .STAGES   (STAGES),
        .FALLBACK (FALLBACK)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_bus  (seed_bus),
        .noise_o   (noise)
    );

    rsch_frame_ctr #(
        .CW_LEN (CW_LEN)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (seed_load),
        .sym_valid (sym_valid),
        .inject_i  (inject),
        .hit_o     (hit_done)
    );

    rsch_inject #(
        .SYM_W    (SYM_W),
        .TRIG_BIT (TRIG_BIT)
    ) u_inject (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .sym_valid (sym_valid),
        .sym_in    (sym_in),
        .noise     (noise),
        .hit_done  (hit_done),
        .inject_o  (inject),
        .out_valid (out_valid),
        .sym_out   (sym_out),
        .err_flag  (err_flag)
    );
endmodule

// File: tb/rsch_chan_err_tb_top.sv
// Bench for rsch_chan_err: behavioural reference model compared every clock.
module rsch_chan_err_tb_top;
    localparam int NS = 7;
    localparam int CL = 7;
    localparam int TB = 2;
    localparam logic [20:0] FB = 21'o1234567;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [20:0] seed_bus = '0;
    logic        sym_valid = 1'b0;
    logic [2:0]  sym_in = '0;
    logic        out_valid;
    logic [2:0]  sym_out;
    logic        err_flag;

    always #10 clk = ~clk;

    rsch_chan_err dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_bus  (seed_bus),
        .sym_valid (sym_valid),
        .sym_in    (sym_in),
        .out_valid (out_valid),
        .sym_out   (sym_out),
        .err_flag  (err_flag)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string req = "R1";

    // Reference model state.
    int st[NS];
    int pos = 0;
    bit hit = 0;
    bit e_v = 0;
    int e_s = 0;
    bit e_e = 0;
    bit lag_load = 0;
    bit lag_vld = 0;
    int lag_sym = 0;
    int frm_n = 0;
    int frm_err = 0;

    // Behavioural model, one step per rising edge.
    always @(posedge clk) begin
        int noise;
        int nz;
        lag_load = seed_load && rst_n;
        lag_vld  = sym_valid;
        lag_sym  = sym_in;
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) st[k] = (FB >> (3*k)) & 7;
            pos = 0; hit = 0; e_v = 0; e_s = 0; e_e = 0;
        end else if (seed_load) begin
            for (int k = 0; k < NS; k++)
                st[k] = (seed_bus == 0) ? ((FB >> (3*k)) & 7) : ((seed_bus >> (3*k)) & 7);
            pos = 0; hit = 0;
            e_v = sym_valid; e_s = sym_valid ? sym_in : 0; e_e = 0;
        end else begin
            noise = st[NS-1];
            e_v = sym_valid; e_e = 0; e_s = sym_valid ? sym_in : 0;
            if (sym_valid) begin
                if (!hit && ((noise >> TB) & 1) && noise != 0) begin
                    e_s = e_s ^ noise; e_e = 1; hit = 1;
                end
                pos++;
                if (pos == CL) begin pos = 0; hit = 0; end
            end
            nz = st[NS-1] ^ st[0];
            for (int k = NS-1; k > 0; k--) st[k] = st[k-1];
            st[0] = nz;
        end
    end

    // Per-clock comparison plus framing and reload observations.
    always @(negedge clk) begin
        if (!done) begin
            string tag;
            tag = e_e ? "R5" : (e_v ? "R7" : "R8");
            total++;
            if (out_valid !== e_v || sym_out !== 3'(e_s) || err_flag !== e_e) begin
                bad++;
                $display("FAIL %s/%s: got v=%0b s=%0d e=%0b expected v=%0b s=%0d e=%0b",
                         tag, req, out_valid, sym_out, err_flag, e_v, e_s, e_e);
            end
            if (lag_load) begin
                frm_n = 0; frm_err = 0;
                if (lag_vld) begin
                    total++;
                    if (err_flag !== 1'b0 || sym_out !== 3'(lag_sym)) begin
                        bad++;
                        $display("FAIL R9: got s=%0d e=%0b expected s=%0d e=0",
                                 sym_out, err_flag, lag_sym);
                    end
                end
            end else if (rst_n && out_valid === 1'b1) begin
                frm_n++;
                if (err_flag === 1'b1) frm_err++;
                if (frm_n == CL) begin
                    total++;
                    if (frm_err > 1) begin
                        bad++;
                        $display("FAIL R6: got %0d errors in codeword expected at most 1", frm_err);
                    end
                    frm_n = 0; frm_err = 0;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(input bit v, input int d);
        @(negedge clk);
        seed_load = 1'b0;
        sym_valid = v;
        sym_in    = 3'(d);
    endtask

    task automatic reseed(input logic [20:0] s, input bit v, input int d);
        @(negedge clk);
        seed_load = 1'b1;
        seed_bus  = s;
        sym_valid = v;
        sym_in    = 3'(d);
    endtask

    initial begin
        // R1: outputs quiet while in reset.
        req = "R1";
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || sym_out !== 3'd0 || err_flag !== 1'b0) begin
            bad++;
            $display("FAIL R1: got v=%0b s=%0d e=%0b expected 0 0 0", out_valid, sym_out, err_flag);
        end
        rst_n = 1'b1;

        // R4: sequence from the reset pattern, continuous symbols.
        req = "R4";
        for (int i = 0; i < 70; i++) drive(1'b1, i % 8);

        // R8: gaps in the symbol stream.
        req = "R8";
        for (int i = 0; i < 60; i++) drive((i % 3) != 0, (i * 5) % 8);

        // R2: explicit seed, then a mix of data.
        req = "R2";
        reseed(21'o7016253, 1'b0, 0);
        for (int i = 0; i < 50; i++) drive(1'b1, (i * 3 + 1) % 8);

        // R3: zero seed falls back to the fixed pattern.
        req = "R3";
        reseed(21'o0, 1'b0, 0);
        for (int i = 0; i < 40; i++) drive(1'b1, 0);

        // R9: reload with a symbol, in the middle of a codeword.
        req = "R9";
        for (int i = 0; i < 3; i++) drive(1'b1, 6);
        reseed(21'o4444444, 1'b1, 5);
        for (int i = 0; i < 30; i++) drive(1'b1, i % 8);
        reseed(21'o0000001, 1'b1, 2);
        for (int i = 0; i < 20; i++) drive((i % 2) == 0, 7);

        // R6: long mixed run.
        req = "R6";
        for (int i = 0; i < 400; i++) drive($urandom_range(0, 3) != 0, $urandom_range(0, 7));
        drive(1'b0, 0);
        drive(1'b0, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule